// File: doc/BRIEF.md
# Task Switch Controller

This block holds the task-related architectural state of a small protected-mode processor core: the current task register (selector plus its hidden base and limit), the nested-task and virtual-mode flag bits, and the task-switched and monitor-coprocessor control bits. The core's decode stage presents events to it: a call or software interrupt that switches tasks, an interrupt taken without a task switch, an interrupt return, a flag pop, a control-register write, and the issue of a floating-point or wait instruction.

For the two events that change tasks, the block runs a fixed sequence of transfers against a separate task-state memory unit. The unit is reached through a single request/acknowledge port. Each step names an operation, a selector and a write value. The step that reads a descriptor or loads the new task's state returns its data with the acknowledge. The block checks and updates the descriptor busy type, writes the back link, and commits the new task register and flags. It also raises a general-protection, debug or device-unavailable exception request, one at a time and in a fixed priority.

While a switch is in progress the block drops its ready output, and every other event is held off until it returns high.

Top module: `task_switch_ctrl`

## Requirements
- R1: After reset, tr_sel, tr_base, tr_limit, st_nt, st_vm, st_ts and st_mp are all zero, ready is 1, and xfer_req and exc_valid are 0.
- R2: Events are accepted only in a cycle where ready is 1. ready is 0 from the cycle after a task switch starts until its last step is acknowledged. Events presented while ready is 0 have no effect. When several are presented together, only one is taken, in the order switch request, interrupt return, interrupt without switch, flag pop, control write. While xfer_req is 1 and not acknowledged, xfer_op and xfer_sel stay stable.
- R3: A switch started by sw_req to selector S runs these steps: op 0 (read descriptor, sel S); op 1 (write type, sel S, wdata 0xB); op 2 (save, sel = current TR, wdata bit0 = NT, bit1 = VM); op 3 (write back link, sel S, wdata = current TR); op 4 (load state, sel S).
- R4: On the acknowledge of the last step of a switch, TR takes the new selector, and base and limit take the values returned by the descriptor read. st_ts is set. st_vm takes xfer_vm. st_nt becomes 1 after a forward switch, or takes xfer_nt after a return switch.
- R5: When the descriptor read of a forward switch returns type 0xB, the switch is abandoned with exception vector 13, and TR and the flags are unchanged.
- R6: An interrupt return with st_nt=1 runs these steps: op 5 (read back link, sel = current TR); op 1 (write type, sel = current TR, wdata 0x9); op 2 (save, sel = current TR); op 0 (read descriptor, sel = link); op 4 (load state, sel = link).
- R7: When xfer_trap is 1 on the acknowledge of the load step, exception vector 1 is raised.
- R8: fpu_issue in a cycle where st_ts=1 and st_mp=1 raises exception vector 7. Otherwise fpu_issue has no effect.
- R9: Exception requests arising in the same cycle are resolved 13 first, then 1, then 7. Only one vector is reported, as a single-cycle exc_valid pulse in the cycle after the cause.
- R10: An interrupt without switch pushes st_nt onto a NT stack of STK_DEPTH entries (the oldest entry is dropped when the stack is full) and clears st_nt. An interrupt return with st_nt=0 pops the stack into st_nt, or loads 0 when the stack is empty.
- R11: A flag pop loads st_nt from popf_nt. A control write loads st_ts from cr0_ts and st_mp from cr0_mp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_req | input | 1 | Call/interrupt task switch request |
| sw_sel | input | SELW | Target task selector |
| iret_req | input | 1 | Interrupt return |
| intr_req | input | 1 | Interrupt taken without task switch |
| popf_req | input | 1 | Flag pop |
| popf_nt | input | 1 | NT value carried by the flag pop |
| cr0_wr | input | 1 | Control register write |
| cr0_ts | input | 1 | Task-switched bit to write |
| cr0_mp | input | 1 | Monitor-coprocessor bit to write |
| fpu_issue | input | 1 | Floating-point or wait instruction issued |
| ready | output | 1 | Block can accept an event |
| xfer_req | output | 1 | Task-state transfer request |
| xfer_op | output | 3 | Transfer operation code (see R3, R6) |
| xfer_sel | output | SELW | Selector for the transfer |
| xfer_wdata | output | SELW | Write value: type, back link or saved flags |
| xfer_ack | input | 1 | Transfer acknowledge, response valid |
| xfer_type | input | 4 | Descriptor type returned by op 0 |
| xfer_base | input | BASEW | Segment base returned by op 0 |
| xfer_limit | input | LIMW | Segment limit returned by op 0 |
| xfer_link | input | SELW | Back link returned by op 5 |
| xfer_trap | input | 1 | Trap-on-entry bit returned by op 4 |
| xfer_vm | input | 1 | Virtual-mode bit returned by op 4 |
| xfer_nt | input | 1 | Saved NT bit returned by op 4 |
| tr_sel | output | SELW | Task register selector |
| tr_base | output | BASEW | Hidden task base |
| tr_limit | output | LIMW | Hidden task limit |
| st_nt | output | 1 | Nested-task flag (EFLAGS bit 14) |
| st_vm | output | 1 | Virtual-mode flag (EFLAGS bit 17) |
| st_ts | output | 1 | Task-switched control bit (CR0 bit 3) |
| st_mp | output | 1 | Monitor-coprocessor control bit |
| exc_valid | output | 1 | Exception request pulse |
| exc_vec | output | 8 | Exception vector: 13, 1 or 7 |

## Verification
The bench aims at a switch whose target is already busy, and in particular the current task itself. A design that skipped the busy check would re-enter that task and write a back link that loops to itself. It drives a floating-point issue in the very cycle a switch is acknowledged. This catches a design that lets vector 7 beat 13 or 1, or that reports two pulses. It also checks that a return switch writes type 0x9 before the load step, and that NT stack overflow drops the oldest entry. A design with these wrong would leave the outgoing task busy forever, or pop a stale NT value. Finally, flag pops and returns presented while a switch is in progress must leave NT untouched.

// File: rtl/tsw_pkg.sv
package tsw_pkg;
  typedef enum logic [2:0] {
    OP_RD_DESC = 3'd0,
    OP_WR_TYPE = 3'd1,
    OP_SAVE    = 3'd2,
    OP_WR_LINK = 3'd3,
    OP_LOAD    = 3'd4,
    OP_RD_LINK = 3'd5
  } tsw_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_LINK,
    ST_WR_TYPE,
    ST_SAVE,
    ST_WR_LINK,
    ST_RD_DESC,
    ST_LOAD
  } tsw_state_e;

  localparam logic [3:0] TSS_AVAIL = 4'h9;
  localparam logic [3:0] TSS_BUSY  = 4'hB;

  localparam logic [7:0] VEC_GP = 8'd13;
  localparam logic [7:0] VEC_DB = 8'd1;
  localparam logic [7:0] VEC_NM = 8'd7;
  localparam int         EXC_N  = 3;
endpackage

// File: rtl/tsw_nt_stack.sv
module tsw_nt_stack #(
  parameter int DEPTH = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic push,
  input  logic pop,
  input  logic din,
  output logic top
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [DEPTH-1:0] bits_q;
  logic [CW-1:0]    cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      bits_q <= '0;
      cnt_q  <= '0;
    end else if (push) begin
      bits_q <= {bits_q[DEPTH-2:0], din};
      if (cnt_q != CW'(DEPTH)) cnt_q <= cnt_q + 1'b1;
    end else if (pop) begin
      bits_q <= {1'b0, bits_q[DEPTH-1:1]};
      if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end
  end

  assign top = (cnt_q != '0) ? bits_q[0] : 1'b0;
endmodule

// File: rtl/tsw_exc_arb.sv
module tsw_exc_arb #(
  parameter int               N    = 3,
  parameter logic [N*8-1:0]   VECS = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] req,
  output logic         exc_valid,
  output logic [7:0]   exc_vec
);
  logic [7:0] win;

  always_comb begin
    win = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (req[k]) win = VECS[k*8 +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      exc_valid <= 1'b0;
      exc_vec   <= '0;
    end else begin
      exc_valid <= |req;
      exc_vec   <= win;
    end
  end
endmodule

// File: rtl/tsw_seq.sv
module tsw_seq
  import tsw_pkg::*;
#(
  parameter int SELW  = 16,
  parameter int BASEW = 32,
  parameter int LIMW  = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_fwd,
  input  logic             start_back,
  input  logic [SELW-1:0]  start_sel,
  input  logic [SELW-1:0]  cur_sel,
  input  logic             cur_nt,
  input  logic             cur_vm,
  input  logic             xfer_ack,
  input  logic [3:0]       xfer_type,
  input  logic [BASEW-1:0] xfer_base,
  input  logic [LIMW-1:0]  xfer_limit,
  input  logic [SELW-1:0]  xfer_link,
  input  logic             xfer_trap,
  output logic             xfer_req,
  output tsw_op_e          xfer_op,
  output logic [SELW-1:0]  xfer_sel,
  output logic [SELW-1:0]  xfer_wdata,
  output logic             commit,
  output logic             dir_back,
  output logic [SELW-1:0]  new_sel,
  output logic [BASEW-1:0] new_base,
  output logic [LIMW-1:0]  new_limit,
  output logic             fault_busy,
  output logic             trap_hit
);
  tsw_state_e       state_q;
  logic             back_q;
  logic [SELW-1:0]  tgt_q;
  logic [BASEW-1:0] base_q;
  logic [LIMW-1:0]  limit_q;
  logic             ack_now;
  logic             use_cur;

  assign xfer_req = (state_q != ST_IDLE);
  assign ack_now  = xfer_req & xfer_ack;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      back_q  <= 1'b0;
      tgt_q   <= '0;
      base_q  <= '0;
      limit_q <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start_fwd) begin
            state_q <= ST_RD_DESC;
            back_q  <= 1'b0;
            tgt_q   <= start_sel;
          end else if (start_back) begin
            state_q <= ST_RD_LINK;
            back_q  <= 1'b1;
          end
        end
        ST_RD_LINK: if (ack_now) begin
          tgt_q   <= xfer_link;
          state_q <= ST_WR_TYPE;
        end
        ST_WR_TYPE: if (ack_now) state_q <= ST_SAVE;
        ST_SAVE:    if (ack_now) state_q <= back_q ? ST_RD_DESC : ST_WR_LINK;
        ST_WR_LINK: if (ack_now) state_q <= ST_LOAD;
        ST_RD_DESC: if (ack_now) begin
          base_q  <= xfer_base;
          limit_q <= xfer_limit;
          if (!back_q && xfer_type == TSS_BUSY) state_q <= ST_IDLE;
          else state_q <= back_q ? ST_LOAD : ST_WR_TYPE;
        end
        ST_LOAD:    if (ack_now) state_q <= ST_IDLE;
        default:    state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    case (state_q)
      ST_RD_LINK: xfer_op = OP_RD_LINK;
      ST_WR_TYPE: xfer_op = OP_WR_TYPE;
      ST_SAVE:    xfer_op = OP_SAVE;
      ST_WR_LINK: xfer_op = OP_WR_LINK;
      ST_LOAD:    xfer_op = OP_LOAD;
      default:    xfer_op = OP_RD_DESC;
    endcase
  end

  assign use_cur = (state_q == ST_SAVE) ||
                   (back_q && (state_q == ST_RD_LINK || state_q == ST_WR_TYPE));
  assign xfer_sel = use_cur ? cur_sel : tgt_q;

  always_comb begin
    case (state_q)
      ST_WR_TYPE: xfer_wdata = {{(SELW-4){1'b0}}, (back_q ? TSS_AVAIL : TSS_BUSY)};
      ST_WR_LINK: xfer_wdata = cur_sel;
      ST_SAVE:    xfer_wdata = {{(SELW-2){1'b0}}, cur_vm, cur_nt};
      default:    xfer_wdata = '0;
    endcase
  end

  assign commit     = ack_now && (state_q == ST_LOAD);
  assign dir_back   = back_q;
  assign new_sel    = tgt_q;
  assign new_base   = base_q;
  assign new_limit  = limit_q;
  assign trap_hit   = commit && xfer_trap;
  assign fault_busy = ack_now && (state_q == ST_RD_DESC) && !back_q &&
                      (xfer_type == TSS_BUSY);
endmodule

// File: rtl/task_switch_ctrl.sv
module task_switch_ctrl
  import tsw_pkg::*;
#(
  parameter int SELW      = 16,
  parameter int BASEW     = 32,
  parameter int LIMW      = 20,
  parameter int STK_DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sw_req,
  input  logic [SELW-1:0]  sw_sel,
  input  logic             iret_req,
  input  logic             intr_req,
  input  logic             popf_req,
  input  logic             popf_nt,
  input  logic             cr0_wr,
  input  logic             cr0_ts,
  input  logic             cr0_mp,
  input  logic             fpu_issue,
  output logic             ready,
  output logic             xfer_req,
  output logic [2:0]       xfer_op,
  output logic [SELW-1:0]  xfer_sel,
  output logic [SELW-1:0]  xfer_wdata,
  input  logic             xfer_ack,
  input  logic [3:0]       xfer_type,
  input  logic [BASEW-1:0] xfer_base,
  input  logic [LIMW-1:0]  xfer_limit,
  input  logic [SELW-1:0]  xfer_link,
  input  logic             xfer_trap,
  input  logic             xfer_vm,
  input  logic             xfer_nt,
  output logic [SELW-1:0]  tr_sel,
  output logic [BASEW-1:0] tr_base,
  output logic [LIMW-1:0]  tr_limit,
  output logic             st_nt,
  output logic             st_vm,
  output logic             st_ts,
  output logic             st_mp,
  output logic             exc_valid,
  output logic [7:0]       exc_vec
);
  localparam logic [EXC_N*8-1:0] VEC_LIST = {VEC_NM, VEC_DB, VEC_GP};

  tsw_op_e          op_w;
  logic             commit, dir_back, fault_busy, trap_hit;
  logic [SELW-1:0]  new_sel;
  logic [BASEW-1:0] new_base;
  logic [LIMW-1:0]  new_limit;
  logic             acc_sw, acc_iret, acc_intr, acc_popf, acc_cr0;
  logic             iret_switch, iret_plain;
  logic             stk_top;
  logic [EXC_N-1:0] exc_req;

  assign ready    = ~xfer_req;
  assign acc_sw   = ready & sw_req;
  assign acc_iret = ready & ~sw_req & iret_req;
  assign acc_intr = ready & ~sw_req & ~iret_req & intr_req;
  assign acc_popf = ready & ~sw_req & ~iret_req & ~intr_req & popf_req;
  assign acc_cr0  = ready & ~sw_req & ~iret_req & ~intr_req & ~popf_req & cr0_wr;

  assign iret_switch = acc_iret & st_nt;
  assign iret_plain  = acc_iret & ~st_nt;

  tsw_seq #(.SELW(SELW), .BASEW(BASEW), .LIMW(LIMW)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .start_fwd  (acc_sw),
    .start_back (iret_switch),
    .start_sel  (sw_sel),
    .cur_sel    (tr_sel),
    .cur_nt     (st_nt),
    .cur_vm     (st_vm),
    .xfer_ack   (xfer_ack),
    .xfer_type  (xfer_type),
    .xfer_base  (xfer_base),
    .xfer_limit (xfer_limit),
    .xfer_link  (xfer_link),
    .xfer_trap  (xfer_trap),
    .xfer_req   (xfer_req),
    .xfer_op    (op_w),
    .xfer_sel   (xfer_sel),
    .xfer_wdata (xfer_wdata),
    .commit     (commit),
    .dir_back   (dir_back),
    .new_sel    (new_sel),
    .new_base   (new_base),
    .new_limit  (new_limit),
    .fault_busy (fault_busy),
    .trap_hit   (trap_hit)
  );

  assign xfer_op = op_w;

  tsw_nt_stack #(.DEPTH(STK_DEPTH)) u_stk (
    .clk  (clk),
    .rst  (rst),
    .push (acc_intr),
    .pop  (iret_plain),
    .din  (st_nt),
    .top  (stk_top)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      tr_sel   <= '0;
      tr_base  <= '0;
      tr_limit <= '0;
      st_nt    <= 1'b0;
      st_vm    <= 1'b0;
      st_ts    <= 1'b0;
      st_mp    <= 1'b0;
    end else begin
      if (commit) begin
        tr_sel   <= new_sel;
        tr_base  <= new_base;
        tr_limit <= new_limit;
        st_vm    <= xfer_vm;
        st_nt    <= dir_back ? xfer_nt : 1'b1;
      end else if (acc_intr) begin
        st_nt <= 1'b0;
      end else if (iret_plain) begin
        st_nt <= stk_top;
      end else if (acc_popf) begin
        st_nt <= popf_nt;
      end
      if (commit) st_ts <= 1'b1;
      else if (acc_cr0) st_ts <= cr0_ts;
      if (acc_cr0) st_mp <= cr0_mp;
    end
  end

  assign exc_req = {fpu_issue & st_ts & st_mp, trap_hit, fault_busy};

  tsw_exc_arb #(.N(EXC_N), .VECS(VEC_LIST)) u_arb (
    .clk       (clk),
    .rst       (rst),
    .req       (exc_req),
    .exc_valid (exc_valid),
    .exc_vec   (exc_vec)
  );
endmodule

// File: rtl/tsw_checker.sv
module tsw_checker #(
  parameter int SELW = 16
) (
  input logic            clk,
  input logic            rst,
  input logic            ready,
  input logic            xfer_req,
  input logic            xfer_ack,
  input logic [2:0]      xfer_op,
  input logic [SELW-1:0] xfer_sel,
  input logic [3:0]      xfer_type,
  input logic [SELW-1:0] tr_sel,
  input logic            st_ts,
  input logic            st_mp,
  input logic            fpu_issue,
  input logic            exc_valid,
  input logic [7:0]      exc_vec
);
  a_r2_ready_low: assert property (@(posedge clk) disable iff (rst)
    xfer_req |-> !ready);

  a_r2_hold_stable: assert property (@(posedge clk) disable iff (rst)
    (xfer_req && !xfer_ack) |=> (xfer_req && $stable(xfer_op) && $stable(xfer_sel)));

  a_r4_tr_on_load: assert property (@(posedge clk) disable iff (rst)
    !$stable(tr_sel) |-> (st_ts && $past(xfer_req && xfer_ack && xfer_op == 3'd4)));

  a_r5_gp_cause: assert property (@(posedge clk) disable iff (rst)
    (exc_valid && exc_vec == 8'd13) |->
      $past(xfer_req && xfer_ack && xfer_op == 3'd0 && xfer_type == 4'hB));

  a_r8_nm_cause: assert property (@(posedge clk) disable iff (rst)
    (exc_valid && exc_vec == 8'd7) |-> $past(fpu_issue && st_ts && st_mp));

  a_r9_vec_legal: assert property (@(posedge clk) disable iff (rst)
    exc_valid |-> (exc_vec == 8'd13 || exc_vec == 8'd1 || exc_vec == 8'd7));
endmodule

bind task_switch_ctrl tsw_checker #(.SELW(SELW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .ready     (ready),
  .xfer_req  (xfer_req),
  .xfer_ack  (xfer_ack),
  .xfer_op   (xfer_op),
  .xfer_sel  (xfer_sel),
  .xfer_type (xfer_type),
  .tr_sel    (tr_sel),
  .st_ts     (st_ts),
  .st_mp     (st_mp),
  .fpu_issue (fpu_issue),
  .exc_valid (exc_valid),
  .exc_vec   (exc_vec)
);

// File: tb/task_switch_ctrl_tb_top.sv
`timescale 1ns/1ps
module task_switch_ctrl_tb_top;
  localparam int SELW = 16, BASEW = 32, LIMW = 20, DEPTH = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic sw_req = 0, iret_req = 0, intr_req = 0, popf_req = 0, popf_nt = 0;
  logic cr0_wr = 0, cr0_ts = 0, cr0_mp = 0, fpu_issue = 0;
  logic [SELW-1:0] sw_sel = '0;
  logic ready, xfer_req;
  logic [2:0] xfer_op;
  logic [SELW-1:0] xfer_sel, xfer_wdata;
  logic xfer_ack = 0, xfer_trap = 0, xfer_vm = 0, xfer_nt = 0;
  logic [3:0] xfer_type = '0;
  logic [BASEW-1:0] xfer_base = '0;
  logic [LIMW-1:0] xfer_limit = '0;
  logic [SELW-1:0] xfer_link = '0;
  logic [SELW-1:0] tr_sel;
  logic [BASEW-1:0] tr_base;
  logic [LIMW-1:0] tr_limit;
  logic st_nt, st_vm, st_ts, st_mp, exc_valid;
  logic [7:0] exc_vec;

  always #2 clk = ~clk;

  task_switch_ctrl #(.SELW(SELW), .BASEW(BASEW), .LIMW(LIMW), .STK_DEPTH(DEPTH)) dut_i (.*);

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // bench model of task-state memory and architectural state
  logic [3:0]       m_type [8];
  logic [BASEW-1:0] m_bs   [8];
  logic [LIMW-1:0]  m_lm   [8];
  logic [SELW-1:0]  m_link [8];
  bit m_trap [8], m_vmb [8], m_ntb [8];
  logic [SELW-1:0] e_tr = '0;
  logic [BASEW-1:0] e_base = '0;
  logic [LIMW-1:0] e_lim = '0;
  bit e_nt = 0, e_vm = 0, e_ts = 0, e_mp = 0;
  logic [DEPTH-1:0] e_stk = '0;
  int e_cnt = 0;

  task automatic chk(input string rq, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic check_state(input string rq);
    chk(rq, "tr_sel", 32'(tr_sel), 32'(e_tr));
    chk(rq, "tr_base", tr_base, e_base);
    chk(rq, "tr_limit", 32'(tr_limit), 32'(e_lim));
    chk(rq, "st_nt", 32'(st_nt), 32'(e_nt));
    chk(rq, "st_vm", 32'(st_vm), 32'(e_vm));
    chk(rq, "st_ts", 32'(st_ts), 32'(e_ts));
    chk(rq, "st_mp", 32'(st_mp), 32'(e_mp));
  endtask

  task automatic chk_exc(input string rq, input bit v, input logic [7:0] vec);
    chk(rq, "exc_valid", 32'(exc_valid), 32'(v));
    if (v) begin
      chk(rq, "exc_vec", 32'(exc_vec), 32'(vec));
      @(negedge clk);
      chk("R9", "single pulse", 32'(exc_valid), 32'd0);
    end
  endtask

  task automatic serve(input logic [2:0] op_e, input logic [SELW-1:0] sel_e,
                       input logic [SELW-1:0] wd_e, input bit chk_wd,
                       input bit fpu_ack, input string rq);
    int n = 0;
    int ix;
    while (!xfer_req && n < 20) begin @(negedge clk); n++; end
    chk(rq, "xfer_req", 32'(xfer_req), 32'd1);
    chk(rq, "xfer_op", 32'(xfer_op), 32'(op_e));
    chk(rq, "xfer_sel", 32'(xfer_sel), 32'(sel_e));
    if (chk_wd) chk(rq, "xfer_wdata", 32'(xfer_wdata), 32'(wd_e));
    repeat ($urandom_range(0, 2)) @(negedge clk);
    ix = int'(sel_e[5:3]);
    xfer_ack = 1; xfer_type = m_type[ix]; xfer_base = m_bs[ix]; xfer_limit = m_lm[ix];
    xfer_link = m_link[ix]; xfer_trap = m_trap[ix]; xfer_vm = m_vmb[ix]; xfer_nt = m_ntb[ix];
    fpu_issue = fpu_ack;
    @(negedge clk);
    xfer_ack = 0; fpu_issue = 0;
  endtask

  task automatic exc_after_switch(input bit trap, input bit fpu, input bit old_ts,
                                  input string rq);
    if (trap) chk_exc("R7", 1, 8'd1);
    else if (fpu && old_ts && e_mp) chk_exc("R8", 1, 8'd7);
    else chk_exc(rq, 0, 8'd0);
  endtask

  task automatic do_call(input int i, input bit fpu, input bit hold);
    logic [SELW-1:0] sel = SELW'(i * 8);
    int ti = int'(e_tr[5:3]);
    bit old_ts = e_ts;
    sw_sel = sel; sw_req = 1;
    @(negedge clk); sw_req = 0;
    chk("R2", "ready during switch", 32'(ready), 32'd0);
    if (hold) begin
      popf_req = 1; popf_nt = ~e_nt; iret_req = 1; intr_req = 1;
      @(negedge clk); popf_req = 0; iret_req = 0; intr_req = 0;
      chk("R2", "nt held off", 32'(st_nt), 32'(e_nt));
    end
    serve(3'd0, sel, '0, 0, (m_type[i] == 4'hB) && fpu, "R3");
    if (m_type[i] == 4'hB) begin
      chk_exc("R5", 1, 8'd13);
      check_state("R5");
      chk("R5", "ready after abort", 32'(ready), 32'd1);
      return;
    end
    serve(3'd1, sel, 16'h000B, 1, 0, "R3"); m_type[i] = 4'hB;
    serve(3'd2, e_tr, {14'b0, e_vm, e_nt}, 1, 0, "R3"); m_ntb[ti] = e_nt; m_vmb[ti] = e_vm;
    serve(3'd3, sel, e_tr, 1, 0, "R3"); m_link[i] = e_tr;
    serve(3'd4, sel, '0, 0, fpu, "R3");
    e_tr = sel; e_base = m_bs[i]; e_lim = m_lm[i]; e_nt = 1; e_vm = m_vmb[i]; e_ts = 1;
    check_state("R4");
    exc_after_switch(m_trap[i], fpu, old_ts, "R4");
  endtask

  task automatic do_iret(input bit fpu);
    int ti = int'(e_tr[5:3]);
    logic [SELW-1:0] lk;
    int li;
    bit old_ts = e_ts;
    iret_req = 1;
    @(negedge clk); iret_req = 0;
    if (!e_nt) begin
      e_nt = (e_cnt > 0) ? e_stk[0] : 1'b0;
      e_stk = e_stk >> 1;
      if (e_cnt > 0) e_cnt--;
      check_state("R10");
      chk_exc("R10", 0, 8'd0);
      return;
    end
    lk = m_link[ti]; li = int'(lk[5:3]);
    serve(3'd5, e_tr, '0, 0, 0, "R6");
    serve(3'd1, e_tr, 16'h0009, 1, 0, "R6"); m_type[ti] = 4'h9;
    serve(3'd2, e_tr, {14'b0, e_vm, e_nt}, 1, 0, "R6"); m_ntb[ti] = e_nt; m_vmb[ti] = e_vm;
    serve(3'd0, lk, '0, 0, 0, "R6");
    serve(3'd4, lk, '0, 0, fpu, "R6");
    e_tr = lk; e_base = m_bs[li]; e_lim = m_lm[li]; e_nt = m_ntb[li]; e_vm = m_vmb[li]; e_ts = 1;
    check_state("R6");
    exc_after_switch(m_trap[li], fpu, old_ts, "R6");
  endtask

  task automatic do_intr();
    intr_req = 1;
    @(negedge clk); intr_req = 0;
    e_stk = {e_stk[DEPTH-2:0], e_nt};
    if (e_cnt < DEPTH) e_cnt++;
    e_nt = 0;
    check_state("R10");
  endtask

  task automatic do_popf(input bit v);
    popf_req = 1; popf_nt = v;
    @(negedge clk); popf_req = 0;
    e_nt = v;
    check_state("R11");
  endtask

  task automatic do_cr0(input bit t, input bit m);
    cr0_wr = 1; cr0_ts = t; cr0_mp = m;
    @(negedge clk); cr0_wr = 0;
    e_ts = t; e_mp = m;
    check_state("R11");
  endtask

  task automatic do_fpu();
    bit hit = e_ts && e_mp;
    fpu_issue = 1;
    @(negedge clk); fpu_issue = 0;
    chk_exc("R8", hit, 8'd7);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5A17_0C3D));
    for (int k = 0; k < 8; k++) begin
      m_type[k] = (k == 0) ? 4'hB : 4'h9;
      m_bs[k] = $urandom(); m_lm[k] = LIMW'($urandom());
      m_link[k] = '0; m_trap[k] = (k >= 4) && ($urandom_range(0, 1) == 1);
      m_vmb[k] = $urandom_range(0, 1) == 1; m_ntb[k] = 0;
    end
    m_trap[2] = 0; m_trap[3] = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check_state("R1");
    chk("R1", "ready", 32'(ready), 32'd1);
    chk("R1", "xfer_req", 32'(xfer_req), 32'd0);
    chk("R1", "exc_valid", 32'(exc_valid), 32'd0);

    do_fpu();
    do_cr0(1, 0); do_fpu();
    do_cr0(1, 1); do_fpu();
    do_cr0(0, 1);
    do_popf(1); do_popf(0); do_popf(1);
    do_intr(); do_intr(); do_iret(0); do_iret(0); do_iret(0);
    do_popf(1);
    for (int k = 0; k < 5; k++) do_intr();
    for (int k = 0; k < 5; k++) do_iret(0);
    // simultaneous intr and popf: intr wins (R2)
    do_popf(1);
    intr_req = 1; popf_req = 1; popf_nt = 1;
    @(negedge clk); intr_req = 0; popf_req = 0;
    e_stk = {e_stk[DEPTH-2:0], e_nt}; if (e_cnt < DEPTH) e_cnt++; e_nt = 0;
    check_state("R2");
    do_iret(0);
    do_call(2, 0, 1);
    do_call(2, 0, 0);
    do_iret(0);
    do_cr0(1, 1);
    do_call(3, 1, 0);
    do_call(3, 1, 0);
    do_iret(1);

    for (int it = 0; it < 400; it++) begin
      case ($urandom_range(0, 9))
        0, 1, 2: do_call($urandom_range(0, 7), 0, 0);
        3, 4:    do_iret($urandom_range(0, 1) == 1);
        5:       do_intr();
        6:       do_popf($urandom_range(0, 1) == 1);
        7:       do_cr0($urandom_range(0, 1) == 1, $urandom_range(0, 3) != 0);
        8:       do_fpu();
        default: do_call($urandom_range(1, 7), 1, $urandom_range(0, 1) == 1);
      endcase
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule